// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers two interrupt sources for a small processor core: an external pin and a one-cycle overflow pulse from a timer. Each source owns an enable bit and a pending flag. A shared global enable, which is also bit 7 of the core's status register, gates every request. When at least one enabled source is pending and the global enable is set, the controller raises a request and presents the vector address of the winning source to the program counter logic.

The external pin can request on a low level, a falling edge or a rising edge, chosen by a two-bit sense field. Edge events and timer overflows latch pending flags. Software clears a flag by writing 1 to its bit, and writing 0 leaves the flag alone. When the core accepts the interrupt, the controller drops the global enable and clears the winner's latched flag. The return-from-interrupt strobe sets the global enable again. A request on the pin in level mode is not latched. It lasts exactly as long as the pin is held low.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the global enable, both enable bits, both pending flags and the sense field are 0, and no request is raised.
- R2: Register selects on `reg_addr` are 0 for the pin enable (bit 6), 1 for the pin flag (bit 6), 2 for the timer enable (bit 1), 3 for the timer flag (bit 1) and 4 for the sense field (bits 1:0). Only these bits are stored, and every other bit reads 0.
- R3: With sense 10 the pin flag is set at the first clock edge that samples the pin low after it was sampled high. A rising transition does not set the flag.
- R4: With sense 11 the pin flag is set at the first clock edge that samples the pin high after it was sampled low. A falling transition does not set the flag.
- R5: With sense 00 the pin requests while it is low. No flag is latched, and the request ends when the pin returns high.
- R6: Sense 01 is reserved. The pin neither latches a flag nor requests in this mode.
- R7: A high `tmr_ovf` at a clock edge sets the timer flag.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A hardware set in the same cycle as a clearing write takes priority, and the flag stays set.
- R9: When both sources are pending and enabled, the vector is that of the pin (1 × VEC_STEP). When only the timer is pending and enabled, the vector is 2 × VEC_STEP.
- R10: A pending source whose enable bit is 0 raises no request and does not hide a lower-priority source that is enabled.
- R11: `irq_req` is 0 while the global enable is 0. A status-register write (`ie_we`) loads the global enable from `ie_d`.
- R12: `irq_ack` while `irq_req` is high clears the global enable at that edge. It also clears the latched flag of the winning source and leaves the other flag unchanged.
- R13: `irq_reti` sets the global enable at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | External interrupt pin, already synchronous to clk |
| tmr_ovf | input | 1 | Timer overflow pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for writes and reads |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| ie_we | input | 1 | Status-register write of the global enable |
| ie_d | input | 1 | New global enable value |
| irq_ack | input | 1 | Core accepts the current request |
| irq_reti | input | 1 | Return from interrupt |
| gie | output | 1 | Global enable (status bit 7) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Vector address of the winning source |

## Verification
The pin is driven through falling, rising, held-low and toggling patterns under each of the four sense codes. Each edge mode must react to its own edge and ignore the opposite one. Level mode must request without latching anything, and the reserved code must do nothing. Priority is tested with both sources pending, with one source masked in each direction and with the global enable off. These cases separate the fixed priority order from the masking of a source. Acknowledge and return sequences, together with writes that clear a flag in the same cycle as a hardware set, show that only the winner's flag is consumed and that a new event is never lost.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int VEC_W    = 10,
  parameter int VEC_STEP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_pin,
  input  logic             tmr_ovf,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             ie_we,
  input  logic             ie_d,
  input  logic             irq_ack,
  input  logic             irq_reti,
  output logic             gie,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);

  localparam logic [2:0] A_PIN_EN  = 3'd0;
  localparam logic [2:0] A_PIN_FLG = 3'd1;
  localparam logic [2:0] A_TMR_EN  = 3'd2;
  localparam logic [2:0] A_TMR_FLG = 3'd3;
  localparam logic [2:0] A_SENSE   = 3'd4;
  localparam int PIN_BIT = 6;
  localparam int TMR_BIT = 1;
  localparam logic [VEC_W-1:0] VEC_PIN = VEC_W'(1 * VEC_STEP);
  localparam logic [VEC_W-1:0] VEC_TMR = VEC_W'(2 * VEC_STEP);

  logic       pin_en, pin_flg, tmr_en, tmr_flg, pin_q;
  logic [1:0] sense;

  wire lvl_mode  = (sense == 2'b00);
  wire edge_mode = sense[1];
  wire pin_hit   = (sense == 2'b10 &&  pin_q && !ext_pin) ||
                   (sense == 2'b11 && !pin_q &&  ext_pin);

  wire pin_pend = lvl_mode ? !ext_pin : (edge_mode & pin_flg);
  wire pin_act  = pin_en & pin_pend;
  wire tmr_act  = tmr_en & tmr_flg;

  assign irq_req = gie & (pin_act | tmr_act);
  assign irq_vec = pin_act ? VEC_PIN : (tmr_act ? VEC_TMR : '0);

  wire take     = irq_ack & irq_req;
  wire take_pin = take & pin_act;
  wire take_tmr = take & !pin_act & tmr_act;

  wire wr_pin_clr = reg_we && reg_addr == A_PIN_FLG && reg_wdata[PIN_BIT];
  wire wr_tmr_clr = reg_we && reg_addr == A_TMR_FLG && reg_wdata[TMR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_en <= 1'b0;
      tmr_en <= 1'b0;
      sense  <= 2'b00;
    end else if (reg_we) begin
      if (reg_addr == A_PIN_EN) pin_en <= reg_wdata[PIN_BIT];
      if (reg_addr == A_TMR_EN) tmr_en <= reg_wdata[TMR_BIT];
      if (reg_addr == A_SENSE)  sense  <= reg_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= ext_pin;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_flg <= 1'b0;
      tmr_flg <= 1'b0;
    end else begin
      if (pin_hit)                                 pin_flg <= 1'b1;
      else if (wr_pin_clr || (take_pin && edge_mode)) pin_flg <= 1'b0;
      if (tmr_ovf)                                 tmr_flg <= 1'b1;
      else if (wr_tmr_clr || take_tmr)             tmr_flg <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        gie <= 1'b0;
    else if (take)     gie <= 1'b0;
    else if (irq_reti) gie <= 1'b1;
    else if (ie_we)    gie <= ie_d;
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      A_PIN_EN:  reg_rdata[PIN_BIT] = pin_en;
      A_PIN_FLG: reg_rdata[PIN_BIT] = pin_flg;
      A_TMR_EN:  reg_rdata[TMR_BIT] = tmr_en;
      A_TMR_FLG: reg_rdata[TMR_BIT] = tmr_flg;
      A_SENSE:   reg_rdata[1:0]     = sense;
      default:   reg_rdata          = 8'h00;
    endcase
  end

  p_ack_drops_gie_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && irq_req |=> !gie);
  p_other_flag_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && irq_req && irq_vec == VEC_PIN && tmr_flg && !wr_tmr_clr |=> tmr_flg);
  p_reti_sets_r13: assert property (@(posedge clk) disable iff (!rst_n)
    irq_reti && !(irq_ack && irq_req) |=> gie);
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tmr_clr && !tmr_ovf |=> !tmr_flg);
  p_w0_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == A_PIN_FLG && !reg_wdata[PIN_BIT] && pin_flg
    && !(irq_ack && irq_req) |=> pin_flg);
  p_reserved_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sense == 2'b01 && !pin_flg |=> !pin_flg);
  p_level_no_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sense == 2'b00 && !pin_flg |=> !pin_flg);
  p_ovf_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> tmr_flg);

endmodule

// File: tb/sim_vec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vec_irq_ctrl;
  localparam int VEC_W = 10;
  localparam int VEC_STEP = 1;
  localparam int F_REQ = 0, F_VEC = 1, F_GIE = 2, F_RD = 3;

  logic clk = 1'b0, rst_n = 1'b0, ext_pin = 1'b1, tmr_ovf = 1'b0;
  logic reg_we = 1'b0, ie_we = 1'b0, ie_d = 1'b0, irq_ack = 1'b0, irq_reti = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic gie, irq_req;
  logic [VEC_W-1:0] irq_vec;

  always #4 clk = ~clk;

  vec_irq_ctrl #(.VEC_W(VEC_W), .VEC_STEP(VEC_STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ie_we(ie_we), .ie_d(ie_d), .irq_ack(irq_ack), .irq_reti(irq_reti),
    .gie(gie), .irq_req(irq_req), .irq_vec(irq_vec));

  typedef struct { string tag; int fld; logic [15:0] exp; } item_t;
  item_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.fld)
        F_REQ:   act = {15'd0, irq_req};
        F_VEC:   act = 16'(irq_vec);
        F_GIE:   act = {15'd0, gie};
        default: act = {8'd0, reg_rdata};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s field %0d: actual %h expected %h", it.tag, it.fld, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, int fld, logic [15:0] exp, logic [2:0] addr = 3'd0);
    item_t it;
    if (fld == F_RD) reg_addr = addr;
    it.tag = tag; it.fld = fld; it.exp = exp;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic set_ie(logic v);
    ie_we = 1'b1; ie_d = v; step(); ie_we = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 req", F_REQ, 0);
    chk("R1 gie", F_GIE, 0);
    for (int a = 0; a < 5; a++) chk("R1 reg", F_RD, 0, 3'(a));

    // R2 map and unused bits
    wr(3'd0, 8'hFF); chk("R2 pin en", F_RD, 16'h40, 3'd0);
    wr(3'd2, 8'hFF); chk("R2 tmr en", F_RD, 16'h02, 3'd2);
    wr(3'd4, 8'hFE); chk("R2 sense", F_RD, 16'h02, 3'd4);
    set_ie(1'b1); chk("R11 ie write", F_GIE, 1);

    // R3 falling edge
    ext_pin = 1'b0; step();
    chk("R3 fall flag", F_RD, 16'h40, 3'd1);
    chk("R3 req", F_REQ, 1);
    chk("R9 pin vec", F_VEC, 16'(VEC_STEP));
    ack();
    chk("R12 gie cleared", F_GIE, 0);
    chk("R12 pin flag consumed", F_RD, 16'h00, 3'd1);
    ext_pin = 1'b1; step();
    chk("R3 rise ignored", F_RD, 16'h00, 3'd1);

    // R4 rising edge
    wr(3'd4, 8'h03);
    ext_pin = 1'b0; step();
    chk("R4 fall ignored", F_RD, 16'h00, 3'd1);
    ext_pin = 1'b1; step();
    chk("R4 rise flag", F_RD, 16'h40, 3'd1);
    wr(3'd1, 8'h00); chk("R8 write0 keeps", F_RD, 16'h40, 3'd1);
    wr(3'd1, 8'h40); chk("R8 write1 clears", F_RD, 16'h00, 3'd1);

    // R5 level
    wr(3'd4, 8'h00); set_ie(1'b1);
    ext_pin = 1'b0; step();
    chk("R5 level req", F_REQ, 1);
    chk("R5 level vec", F_VEC, 16'(VEC_STEP));
    chk("R5 no latch", F_RD, 16'h00, 3'd1);
    ext_pin = 1'b1; step();
    chk("R5 level released", F_REQ, 0);

    // R6 reserved
    wr(3'd4, 8'h01);
    ext_pin = 1'b0; step();
    chk("R6 no req", F_REQ, 0);
    ext_pin = 1'b1; step();
    chk("R6 no flag", F_RD, 16'h00, 3'd1);

    // R7 timer
    tmr_ovf = 1'b1; step(); tmr_ovf = 1'b0;
    chk("R7 tmr flag", F_RD, 16'h02, 3'd3);
    chk("R9 tmr vec", F_VEC, 16'(2*VEC_STEP));

    // R9 priority and R12 selective clear
    wr(3'd4, 8'h02);
    ext_pin = 1'b0; step();
    chk("R9 both pending vec", F_VEC, 16'(VEC_STEP));
    ack();
    chk("R12 tmr flag kept", F_RD, 16'h02, 3'd3);
    chk("R12 no req after ack", F_REQ, 0);
    irq_reti = 1'b1; step(); irq_reti = 1'b0;
    chk("R13 reti gie", F_GIE, 1);
    chk("R13 tmr now wins", F_VEC, 16'(2*VEC_STEP));

    // R10 masking
    wr(3'd2, 8'h00);
    chk("R10 tmr masked", F_REQ, 0);
    chk("R10 tmr flag held", F_RD, 16'h02, 3'd3);
    ext_pin = 1'b1; step(); ext_pin = 1'b0; step();
    wr(3'd0, 8'h00); wr(3'd2, 8'h02);
    chk("R10 masked pin not hiding", F_VEC, 16'(2*VEC_STEP));
    chk("R10 req", F_REQ, 1);

    // R11 global enable off
    set_ie(1'b0);
    chk("R11 gated", F_REQ, 0);

    // R8 set wins over clearing write
    reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h02; tmr_ovf = 1'b1;
    step(); reg_we = 1'b0; tmr_ovf = 1'b0;
    chk("R8 set wins", F_RD, 16'h02, 3'd3);
    wr(3'd3, 8'h02);
    chk("R8 cleared", F_RD, 16'h00, 3'd3);

    @(negedge clk); #1;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule